// File: doc/BRIEF.md
# Secondary interrupt concentrator with direct forwarding

The block gathers 32 level-sensitive interrupt request lines into one summary request for a primary interrupt controller. It samples the request lines into a raw level vector on every clock. An enable mask chosen by software decides which of those levels count toward the summary output. The summary output is high whenever any line is both raised and enabled.

A separate forwarding enable covers the group of lines 21 to 30. For each line in that group whose forwarding bit is set, the block copies the line's raw level straight onto a dedicated output toward the primary controller. That output does not depend on the enable mask. The forwarding enable can only ever hold bits inside that group. A spare soft-request register pair gives software set and clear access to mask bit 0.

Software reaches the block through a plain 32-bit register port. The port addresses whole words: byte offset = 4 × word index, inside a 4 KB window. Each request takes one cycle, and there is no back-pressure, so a request is accepted in the cycle it is presented. Read data appears on the next cycle and holds until the next read.

Top module: `sic_passthru`

## Requirements
- R1: Synchronous active-high reset clears the enable mask, the forwarding enable, `irq_out`, `pass_out` and `bus_rdata`.
- R2: `irq_out` is high exactly when (raw level AND enable mask) is non-zero. A change on `irq_in` reaches `irq_out` after two clock edges. A change of the mask reaches `irq_out` one edge after the write.
- R3: Reading word 0 returns raw level AND mask, word 1 returns the raw level, and word 2 returns the mask. Read data is valid on the cycle after the request.
- R4: Writing word 2 ORs the write data into the mask. Writing word 3 clears every mask bit that is set in the write data.
- R5: Writing a non-zero value to word 4 sets mask bit 0, and writing a non-zero value to word 5 clears mask bit 0. A zero write to either word leaves the mask unchanged. Reading word 4 returns raw level bit 0 in bit 0, with all other bits zero.
- R6: Writing word 8 ORs (write data AND 0x7FE00000) into the forwarding enable, so only bits 21 to 30 can ever be set. Reading word 8 returns the forwarding enable.
- R7: Writing word 9 clears every forwarding enable bit that is set in the write data.
- R8: `pass_out[i]` carries raw level of line 21+i AND forwarding enable bit 21+i, for i = 0 to 9. It has the same latency as `irq_out` and is low while its enable bit is clear.
- R9: Reads of words 3, 5, 6, 7 and any word from 10 up return zero. Writes to any word other than 2, 3, 4, 5, 8 or 9 change neither the mask nor the forwarding enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive interrupt request lines |
| bus_req | input | 1 | Register access request, accepted in the same cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 10 | Word index within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_out | output | 1 | Summary request to the primary controller |
| pass_out | output | 10 | Forwarded levels of lines 21 to 30 (bit 0 = line 21) |

## Verification
The bench hits the forwarding write with all ones. A design that skipped the 0x7FE00000 filter would read back stray bits and could drive unintended lines. It checks that zero writes to the soft-request pair leave mask bit 0 alone; a design that ignored the value test would toggle the bit on any write. It checks that set writes accumulate instead of overwriting, which catches a design that assigns in place of OR. It also checks that `pass_out` tracks only enabled lines within the group, so a design that gated forwarding with the interrupt mask, or forwarded disabled lines, would drive the wrong bits.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int WORD_W = 10;

  // word indices of the register window (byte offset = 4 * index)
  localparam logic [WORD_W-1:0] W_STAT    = 10'd0;
  localparam logic [WORD_W-1:0] W_RAW     = 10'd1;
  localparam logic [WORD_W-1:0] W_ENSET   = 10'd2;
  localparam logic [WORD_W-1:0] W_ENCLR   = 10'd3;
  localparam logic [WORD_W-1:0] W_SOFTSET = 10'd4;
  localparam logic [WORD_W-1:0] W_SOFTCLR = 10'd5;
  localparam logic [WORD_W-1:0] W_FWDSET  = 10'd8;
  localparam logic [WORD_W-1:0] W_FWDCLR  = 10'd9;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] fwd_q
);
  localparam int PT_N = PT_HI - PT_LO + 1;
  localparam logic [NLINES-1:0] FWD_KEEP =
    {{(NLINES-PT_N){1'b0}}, {PT_N{1'b1}}} << PT_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      fwd_q  <= '0;
    end else if (wr_en) begin
      case (word)
        W_ENSET:   mask_q <= mask_q | wdata;
        W_ENCLR:   mask_q <= mask_q & ~wdata;
        W_SOFTSET: if (|wdata) mask_q[0] <= 1'b1;
        W_SOFTCLR: if (|wdata) mask_q[0] <= 1'b0;
        W_FWDSET:  fwd_q <= fwd_q | (wdata & FWD_KEEP);
        W_FWDCLR:  fwd_q <= fwd_q & ~wdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/sic_readmux.sv
module sic_readmux
  import sic_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] word,
  input  logic [NLINES-1:0] level,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] fwd,
  output logic [NLINES-1:0] rdata_q
);
  logic [NLINES-1:0] sel;

  always_comb begin
    case (word)
      W_STAT:    sel = level & mask;
      W_RAW:     sel = level;
      W_ENSET:   sel = mask;
      W_SOFTSET: sel = {{(NLINES-1){1'b0}}, level[0]};
      W_FWDSET:  sel = fwd;
      default:   sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel;
  end
endmodule

// File: rtl/sic_outputs.sv
module sic_outputs #(
  parameter int NLINES = 32,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NLINES-1:0]        irq_in,
  input  logic [NLINES-1:0]        mask,
  input  logic [NLINES-1:0]        fwd,
  output logic [NLINES-1:0]        level_q,
  output logic                     irq_q,
  output logic [PT_HI-PT_LO:0]     pass_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      level_q <= irq_in;
      irq_q   <= |(level_q & mask);
    end
  end

  for (genvar i = 0; i <= PT_HI - PT_LO; i++) begin : g_fwd
    always_ff @(posedge clk) begin
      if (rst) pass_q[i] <= 1'b0;
      else     pass_q[i] <= level_q[PT_LO+i] & fwd[PT_LO+i];
    end
  end
endmodule

// File: rtl/sic_passthru.sv
module sic_passthru
  import sic_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NLINES-1:0]    irq_in,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [WORD_W-1:0]    bus_word,
  input  logic [NLINES-1:0]    bus_wdata,
  output logic [NLINES-1:0]    bus_rdata,
  output logic                 irq_out,
  output logic [PT_HI-PT_LO:0] pass_out
);
  logic [NLINES-1:0] mask_q;
  logic [NLINES-1:0] fwd_q;
  logic [NLINES-1:0] level_q;
  logic              wr_en;
  logic              rd_en;

  assign wr_en = bus_req & bus_we;
  assign rd_en = bus_req & ~bus_we;

  sic_regs #(.NLINES(NLINES), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .word(bus_word),
    .wdata(bus_wdata), .mask_q(mask_q), .fwd_q(fwd_q)
  );

  sic_outputs #(.NLINES(NLINES), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_out (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask(mask_q), .fwd(fwd_q),
    .level_q(level_q), .irq_q(irq_out), .pass_q(pass_out)
  );

  sic_readmux #(.NLINES(NLINES)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .word(bus_word),
    .level(level_q), .mask(mask_q), .fwd(fwd_q), .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/sic_passthru_chk.sv
module sic_passthru_chk
  import sic_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NLINES-1:0]    irq_in,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [WORD_W-1:0]    bus_word,
  input logic [NLINES-1:0]    bus_wdata,
  input logic [NLINES-1:0]    mask,
  input logic [NLINES-1:0]    fwd,
  input logic                 irq_out,
  input logic [PT_HI-PT_LO:0] pass_out
);
  localparam int PT_N = PT_HI - PT_LO + 1;
  localparam logic [NLINES-1:0] FWD_KEEP =
    {{(NLINES-PT_N){1'b0}}, {PT_N{1'b1}}} << PT_LO;

  logic [1:0]      age;
  logic            live;
  logic [PT_N-1:0] in_slice;
  logic [PT_N-1:0] fwd_slice;
  logic            wr;
  logic            known;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign live      = age >= 2'd2;
  assign in_slice  = irq_in[PT_HI:PT_LO];
  assign fwd_slice = fwd[PT_HI:PT_LO];
  assign wr        = bus_req & bus_we;
  assign known     = bus_word inside {W_ENSET, W_ENCLR, W_SOFTSET,
                                      W_SOFTCLR, W_FWDSET, W_FWDCLR};

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '0 && fwd == '0 && !irq_out && pass_out == '0));

  assert_summary_R2: assert property (@(posedge clk) disable iff (rst)
    live |-> irq_out == |($past(irq_in, 2) & $past(mask)));

  assert_enset_or_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_word == W_ENSET) |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

  assert_fwd_group_R6: assert property (@(posedge clk) disable iff (rst)
    (fwd & ~FWD_KEEP) == '0);

  assert_fwdclr_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_word == W_FWDCLR) |=> ((fwd & $past(bus_wdata)) == '0));

  assert_forward_R8: assert property (@(posedge clk) disable iff (rst)
    live |-> pass_out == ($past(in_slice, 2) & $past(fwd_slice)));

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && !known) |=> ($stable(mask) && $stable(fwd)));
endmodule

bind sic_passthru sic_passthru_chk #(.NLINES(NLINES), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .bus_req(bus_req), .bus_we(bus_we),
  .bus_word(bus_word), .bus_wdata(bus_wdata), .mask(mask_q), .fwd(fwd_q),
  .irq_out(irq_out), .pass_out(pass_out)
);

// File: tb/sic_passthru_tb.sv
`timescale 1ns/1ps
module sic_passthru_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic [9:0]  pass_out;

  int tests = 0;
  int fails = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  sic_passthru u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .pass_out(pass_out)
  );

  // columns: irq_in, mask, expected status, expected irq_out
  localparam logic [31:0] VEC [5][4] = '{
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'd1},
    '{32'hF0F0_0000, 32'h0F0F_0000, 32'h0000_0000, 32'd0},
    '{32'h8000_0000, 32'h8000_0001, 32'h8000_0000, 32'd1},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'd0},
    '{32'h1234_5678, 32'h0000_FF00, 32'h0000_5600, 32'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rdw(input logic [9:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_word = w;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
    chk("R1 pass_out", {22'd0, pass_out}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rdw(10'd2, rd); chk("R1 mask", rd, 32'd0);
    rdw(10'd8, rd); chk("R1 fwd", rd, 32'd0);

    // R2/R3 vector table
    for (int i = 0; i < 5; i++) begin
      wr(10'd3, 32'hFFFF_FFFF);
      wr(10'd2, VEC[i][1]);
      @(negedge clk); irq_in = VEC[i][0];
      settle();
      rdw(10'd0, rd); chk("R3 status", rd, VEC[i][2]);
      rdw(10'd1, rd); chk("R3 raw", rd, VEC[i][0]);
      rdw(10'd2, rd); chk("R3 mask", rd, VEC[i][1]);
      chk("R2 irq_out", {31'd0, irq_out}, VEC[i][3]);
    end

    // R4 set accumulates, clear removes
    irq_in = '0;
    wr(10'd3, 32'hFFFF_FFFF);
    wr(10'd2, 32'h0000_00F0);
    wr(10'd2, 32'h0000_0F00);
    rdw(10'd2, rd); chk("R4 set OR", rd, 32'h0000_0FF0);
    wr(10'd3, 32'h0000_0030);
    rdw(10'd2, rd); chk("R4 clear", rd, 32'h0000_0FC0);

    // R5 soft pair
    wr(10'd4, 32'd0);
    rdw(10'd2, rd); chk("R5 zero set ignored", rd, 32'h0000_0FC0);
    wr(10'd4, 32'd5);
    rdw(10'd2, rd); chk("R5 set bit0", rd, 32'h0000_0FC1);
    wr(10'd5, 32'd0);
    rdw(10'd2, rd); chk("R5 zero clr ignored", rd, 32'h0000_0FC1);
    wr(10'd5, 32'h8000_0000);
    rdw(10'd2, rd); chk("R5 clr bit0", rd, 32'h0000_0FC0);
    @(negedge clk); irq_in = 32'h0000_0001; settle();
    rdw(10'd4, rd); chk("R5 read level0 high", rd, 32'd1);
    @(negedge clk); irq_in = 32'hFFFF_FFFE; settle();
    rdw(10'd4, rd); chk("R5 read level0 low", rd, 32'd0);

    // R6/R7 forwarding enable
    wr(10'd8, 32'hFFFF_FFFF);
    rdw(10'd8, rd); chk("R6 filtered set", rd, 32'h7FE0_0000);
    wr(10'd9, 32'h0060_0000);
    rdw(10'd8, rd); chk("R7 clear", rd, 32'h7F80_0000);

    // R8 forwarding
    @(negedge clk); irq_in = 32'hFFFF_FFFF; settle();
    chk("R8 all high", {22'd0, pass_out}, 32'h0000_03FC);
    @(negedge clk); irq_in = 32'h4020_0000; settle();
    chk("R8 sparse", {22'd0, pass_out}, 32'h0000_0200);
    wr(10'd9, 32'hFFFF_FFFF); settle();
    chk("R8 disabled low", {22'd0, pass_out}, 32'd0);

    // R9 undefined offsets
    wr(10'd8, 32'h0100_0000);
    irq_in = 32'hFFFF_FFFF;
    wr(10'd6, 32'hFFFF_FFFF);
    wr(10'd0, 32'hFFFF_FFFF);
    wr(10'd1, 32'h0000_0000);
    wr(10'd10, 32'h0000_0000);
    rdw(10'd2, rd); chk("R9 mask untouched", rd, 32'h0000_0FC0);
    rdw(10'd8, rd); chk("R9 fwd untouched", rd, 32'h0100_0000);
    rdw(10'd6, rd); chk("R9 read word6", rd, 32'd0);
    rdw(10'd3, rd); chk("R9 read word3", rd, 32'd0);
    rdw(10'h3FF, rd); chk("R9 read top", rd, 32'd0);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; irq_in = '0;
    chk("R1 irq after rst", {31'd0, irq_out}, 32'd0);
    chk("R1 pass after rst", {22'd0, pass_out}, 32'd0);
    rdw(10'd2, rd); chk("R1 mask after rst", rd, 32'd0);
    rdw(10'd8, rd); chk("R1 fwd after rst", rd, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule